// File: doc/BRIEF.md
# Counter-Timed Delta-Sigma Loop Controller

This block is the digital timing core of a delta-sigma phase-locked loop. That loop turns a hard-limited FM signal into a 2-bit noise-shaped code stream. The core runs on a fast reference clock. A small period counter produces a carry pulse. The time between two carries is the loop's feedback quantity. Each rising edge of the limited input opens a charge-up gate, and the next carry closes it. Each carry also opens a discharge gate of fixed length. An external charge pump, capacitor and 2-bit converter turn those two gates into a code. The core strobes that converter, registers the code it returns and presents it on an output strobe. It also uses the code to choose the counter's next reload value, which sets when the next carry arrives.

The returned code goes through a short parameterised FIR. The FIR is pass-through by default, and its result is clamped to the counter range. A constant is added, and the sum is loaded into the counter. Two reload schemes give the same carry instants. In the first, the base plus one is loaded two cycles after the carry, after the counter has wrapped. In the second, the base value is loaded one cycle after the carry. A parameter selects the scheme. The asynchronous limited input is synchronised before its rising edges are detected.

Top module: `fdc_timing_core`

## Requirements
- R1: While rst_n is low at a rising clock edge, charge_gate, discharge_gate, adc_strobe, out_strobe and out_code are all 0 and the period counter is preset to 8. The first carry, seen as discharge_gate rising, occurs at the 7th rising edge after the first edge that samples rst_n high.
- R2: A low-to-high change of lim_in that lasts at least two clock cycles sets charge_gate at the third rising edge after the change. That delay comes from two synchroniser flops and one edge-detect flop. If this set and a carry land on the same edge, the set wins.
- R3: charge_gate is cleared at the same rising edge at which the carry rises, unless a set lands on that edge.
- R4: discharge_gate rises at the rising edge that raises the carry. It stays high for three and a half clock periods and falls on a falling edge.
- R5: adc_strobe rises on the falling edge half a cycle after the carry rises, and falls on the next falling edge.
- R6: adc_code is sampled at the rising edge that ends the carry cycle. It appears on out_code (bit 1 is the MSB, value 0..3) from that edge on. out_strobe is high for exactly the one cycle that follows the carry cycle.
- R7: With the default pass-through filter, a sampled code v (0..3) places the next carry 8 - v cycles after the current one. Code 0 therefore gives 8 cycles and code 3 gives 5 cycles.
- R8: The reload scheme that loads base plus one after the wrap and the scheme that loads the base at the carry produce identical outputs, cycle for cycle and on both clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lim_in | input | 1 | Hard-limited input, asynchronous to clk |
| adc_code | input | CODE_W | Code returned by the external converter |
| charge_gate | output | 1 | Enables the positive charge source |
| discharge_gate | output | 1 | Enables the negative charge source for 3.5 cycles |
| adc_strobe | output | 1 | Sample command to the external converter |
| out_strobe | output | 1 | Marks a new value on out_code |
| out_code | output | CODE_W | Registered loop output code |

## Verification
On every cycle, the embedded assertions check the following. A detected input edge must raise the charge gate, and a carry without a coincident set must find that gate closed. The discharge gate must stay high through the carry and the two cycles after it. The converter strobe must already be high when the carry cycle ends. The strobed output must equal the code sampled one edge earlier. Other behaviour appears only in the bench's scenarios: the code-dependent carry spacing, the half-cycle end of the discharge gate, the first carry after reset, the set-over-clear priority and the agreement of the two reload schemes. The bench checks these against its own loop model, using random codes and constant and alternating extreme codes.

// File: rtl/fdc_loop_pkg.sv
// Shared definitions for the delta-sigma loop timing core.
// Assumes: nothing beyond IEEE 1800-2017 package semantics.
package fdc_loop_pkg;

    // Reload scheme of the period counter; both give identical carry instants.
    typedef enum logic {
        LOAD_AFTER_WRAP = 1'b0,   // load base+1 two cycles after carry
        LOAD_AT_CARRY   = 1'b1    // load base one cycle after carry
    } load_scheme_e;

    // Width of the converter code used throughout the loop.
    localparam int unsigned LOOP_CODE_W = 2;

endpackage

// File: rtl/fdc_edge_sync.sv
// Synchroniser plus rising-edge detector for the asynchronous limited input.
// Assumes: the input stays at each level for at least two clk cycles.
// Output 'rise' is a one-cycle pulse STAGES cycles after the change is
// first captured.
module fdc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // chain[0..STAGES-1] synchronise, chain[STAGES] remembers the last level.
    logic [STAGES:0] chain_q;

    // Shift the input through the synchroniser and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i <= STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/fdc_loop_filter.sv
// Short FIR over recent converter codes, plus a constant, clamped to the
// counter range. Combinational only.
// Assumes: tap 0 is the newest code; codes are unsigned; coefficients signed.
module fdc_loop_filter #(
    parameter int unsigned TAPS   = 1,
    parameter int unsigned CODE_W = 2,
    parameter int unsigned COEF_W = 4,
    parameter logic [TAPS*COEF_W-1:0] COEFS = 4'd1,
    parameter int          OFFSET = 9,
    parameter int unsigned OUT_W  = 4
) (
    input  logic [TAPS*CODE_W-1:0] taps,
    output logic [OUT_W-1:0]       load_val
);
    localparam int unsigned ACC_W = COEF_W + CODE_W + $clog2(TAPS + 1) + OUT_W + 8;
    localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((1 << OUT_W) - 1);

    logic signed [ACC_W-1:0]  acc;
    logic signed [COEF_W-1:0] coef_s;
    logic signed [CODE_W:0]   code_s;

    // Weighted sum of the taps plus the reload constant.
    always_comb begin
        acc    = ACC_W'(OFFSET);
        coef_s = '0;
        code_s = '0;
        for (int k = 0; k < TAPS; k++) begin
            coef_s = signed'(COEFS[k*COEF_W +: COEF_W]);
            code_s = signed'({1'b0, taps[k*CODE_W +: CODE_W]});
            acc    = acc + ACC_W'(coef_s) * ACC_W'(code_s);
        end
    end

    // Saturate to the range the period counter can hold.
    always_comb begin
        if (acc[ACC_W-1]) begin
            load_val = '0;
        end else if (acc > MAX_V) begin
            load_val = '1;
        end else begin
            load_val = acc[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/fdc_period_ctr.sv
// Free-running period counter whose terminal count is the loop carry.
// After each carry it is reloaded with the filtered value, which sets the
// time to the next carry. SCHEME selects the reload instant.
// Assumes: load_val is valid in the cycle the reload is taken.
module fdc_period_ctr
    import fdc_loop_pkg::*;
#(
    parameter int unsigned  CNT_W     = 4,
    parameter int unsigned  LOAD_BASE = 8,
    parameter load_scheme_e SCHEME    = LOAD_AFTER_WRAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_val,
    output logic             carry,
    output logic             carry_next
);
    localparam logic [CNT_W-1:0] TERM   = '1;
    localparam logic [CNT_W-1:0] BASE_V = CNT_W'(LOAD_BASE);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             carry_q;
    logic             load_now;

    generate
        if (SCHEME == LOAD_AT_CARRY) begin : g_load_at_carry
            // Reload on the edge that ends the carry cycle.
            assign load_now = carry_q;
        end else begin : g_load_after_wrap
            logic wrap_q;
            // Remember the carry so the reload follows the wrap to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) wrap_q <= 1'b0;
                else        wrap_q <= carry_q;
            end
            assign load_now = wrap_q;

            // R7: after a wrap the counter reads zero, so no back-to-back carry.
            p_no_double_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
                carry_q |=> !carry_q);
        end
    endgenerate

    // Next count: reload or increment with natural wrap.
    always_comb begin
        cnt_d      = load_now ? load_val : cnt_q + CNT_W'(1);
        carry_next = (cnt_d == TERM);
    end

    // Count register and registered carry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= BASE_V;
            carry_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            carry_q <= carry_next;
        end
    end

    assign carry = carry_q;

endmodule

// File: rtl/fdc_strobe_gen.sv
// Derives the discharge gate, converter strobe and output strobe from the
// carry pulse. The discharge gate lasts DIS_FULL+0.5 periods; the half
// period comes from a falling-edge flop.
// Assumes: carry is a registered one-cycle pulse; DIS_FULL >= 2.
module fdc_strobe_gen #(
    parameter int unsigned DIS_FULL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carry,
    output logic discharge_gate,
    output logic adc_strobe,
    output logic out_strobe
);
    localparam int unsigned DLY = DIS_FULL - 1;

    logic [DLY:1] dly_q;
    logic         half_q;
    logic         adc_q;

    // Delay line of the carry on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else begin
            dly_q[1] <= carry;
            for (int i = 2; i <= DLY; i++) begin
                dly_q[i] <= dly_q[i-1];
            end
        end
    end

    // Half-cycle extension of the last delayed carry, plus the converter strobe.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            adc_q  <= 1'b0;
        end else begin
            half_q <= dly_q[DLY];
            adc_q  <= carry;
        end
    end

    assign discharge_gate = carry | (|dly_q) | half_q;
    assign adc_strobe     = adc_q;
    assign out_strobe     = dly_q[1];

    // R4: discharge stays open through the carry cycle and the two after it.
    p_discharge_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> discharge_gate ##1 discharge_gate ##1 discharge_gate);

    // R5: the converter has already been strobed when the carry cycle ends.
    p_adc_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> adc_strobe);

endmodule

// File: rtl/fdc_timing_core.sv
// Digital timing core of a counter-based delta-sigma loop. Opens the charge
// gate on each synchronised input rising edge and closes it on the carry.
// Times the discharge gate and converter strobes, registers the returned
// code and reloads the period counter from the filtered code.
// Assumes: adc_code is settled before the rising edge that ends the carry
// cycle; lim_in holds each level for at least two cycles.
module fdc_timing_core
    import fdc_loop_pkg::*;
#(
    parameter int unsigned  CODE_W      = LOOP_CODE_W,
    parameter int unsigned  CNT_W       = 4,
    parameter int unsigned  LOAD_BASE   = 8,
    parameter load_scheme_e SCHEME      = LOAD_AFTER_WRAP,
    parameter int unsigned  TAPS        = 1,
    parameter int unsigned  COEF_W      = 4,
    parameter logic [TAPS*COEF_W-1:0] COEFS = 4'd1,
    parameter int unsigned  DIS_FULL    = 3,
    parameter int unsigned  SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lim_in,
    input  logic [CODE_W-1:0] adc_code,
    output logic              charge_gate,
    output logic              discharge_gate,
    output logic              adc_strobe,
    output logic              out_strobe,
    output logic [CODE_W-1:0] out_code
);
    localparam bit          AT_CARRY    = (SCHEME == LOAD_AT_CARRY);
    localparam int          LOAD_OFFSET = AT_CARRY ? int'(LOAD_BASE) : int'(LOAD_BASE) + 1;
    localparam int unsigned HIST_D      = (AT_CARRY && TAPS > 1) ? TAPS - 1 : TAPS;

    logic                   in_rise;
    logic                   gate_q;
    logic                   carry;
    logic                   carry_next;
    logic [CNT_W-1:0]       load_val;
    logic [CODE_W-1:0]      hist_q [HIST_D];
    logic [TAPS*CODE_W-1:0] taps;

    fdc_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lim_in),
        .rise     (in_rise)
    );

    // Charge gate: set by an input edge (wins), cleared with the rising carry.
    always_ff @(posedge clk) begin
        if (!rst_n)          gate_q <= 1'b0;
        else if (in_rise)    gate_q <= 1'b1;
        else if (carry_next) gate_q <= 1'b0;
    end

    // Code history: capture the converter code at the end of each carry cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(HIST_D); k++) hist_q[k] <= '0;
        end else if (carry) begin
            hist_q[0] <= adc_code;
            for (int k = 1; k < int'(HIST_D); k++) hist_q[k] <= hist_q[k-1];
        end
    end

    // Filter taps: live code for the early reload, stored code for the late one.
    generate
        if (AT_CARRY) begin : g_taps_live
            assign taps[CODE_W-1:0] = adc_code;
            for (genvar k = 1; k < TAPS; k++) begin : g_old
                assign taps[k*CODE_W +: CODE_W] = hist_q[k-1];
            end
        end else begin : g_taps_stored
            for (genvar k = 0; k < TAPS; k++) begin : g_old
                assign taps[k*CODE_W +: CODE_W] = hist_q[k];
            end
        end
    endgenerate

    fdc_loop_filter #(
        .TAPS   (TAPS),
        .CODE_W (CODE_W),
        .COEF_W (COEF_W),
        .COEFS  (COEFS),
        .OFFSET (LOAD_OFFSET),
        .OUT_W  (CNT_W)
    ) u_filter (
        .taps     (taps),
        .load_val (load_val)
    );

    fdc_period_ctr #(
        .CNT_W     (CNT_W),
        .LOAD_BASE (LOAD_BASE),
        .SCHEME    (SCHEME)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_val   (load_val),
        .carry      (carry),
        .carry_next (carry_next)
    );

    fdc_strobe_gen #(
        .DIS_FULL (DIS_FULL)
    ) u_strobe (
        .clk            (clk),
        .rst_n          (rst_n),
        .carry          (carry),
        .discharge_gate (discharge_gate),
        .adc_strobe     (adc_strobe),
        .out_strobe     (out_strobe)
    );

    assign charge_gate = gate_q;
    assign out_code    = hist_q[0];

    // R2: a detected input edge always opens the charge gate.
    p_charge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_rise |=> charge_gate);

    // R3: during a carry the gate is closed unless an edge set it on that edge.
    p_charge_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !$past(in_rise)) |-> !charge_gate);

    // R6: the strobed output equals the code sampled at the previous edge.
    p_out_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> (out_code == $past(adc_code)));

endmodule

// File: tb/fdc_timing_core_tb_top.sv
// Self-checking bench: both reload schemes side by side, random and directed
// converter codes, random input edges, checked against a bench loop model.
module fdc_timing_core_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lim_in = 1'b0;
    logic [1:0] adc_code = 2'd0;

    logic       chg_i, dis_i, astb_i, ostb_i;
    logic [1:0] code_i;
    logic       chg_e, dis_e, astb_e, ostb_e;
    logic [1:0] code_e;

    always #2.5 clk = ~clk;

    fdc_timing_core dut_i (
        .clk(clk), .rst_n(rst_n), .lim_in(lim_in), .adc_code(adc_code),
        .charge_gate(chg_i), .discharge_gate(dis_i), .adc_strobe(astb_i),
        .out_strobe(ostb_i), .out_code(code_i));

    fdc_timing_core #(.SCHEME(fdc_loop_pkg::LOAD_AT_CARRY)) dut_e (
        .clk(clk), .rst_n(rst_n), .lim_in(lim_in), .adc_code(adc_code),
        .charge_gate(chg_e), .discharge_gate(dis_e), .adc_strobe(astb_e),
        .out_strobe(ostb_e), .out_code(code_e));

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit in_rst = 1'b1;
    int rst_cycles = 0;
    int last_carry = -1000;
    int exp_next = -1;
    int carries_since_rst = 0;
    int pend_set = -1;
    bit exp_chg = 1'b0;
    int v_last = 0;
    int lim_timer = 3;
    bit lim_en = 1'b0;
    int mode = 0;
    int alt = 0;
    bit prev_dis = 1'b0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, what, cyc, act, exp);
        end
    endtask

    // R7: carry spacing for a pass-through filter.
    function automatic int period_for(input int v);
        return 8 - v;
    endfunction

    function automatic int pick_code();
        int v;
        case (mode)
            1:       v = 0;
            2:       v = 3;
            3:       begin v = (alt % 2 == 0) ? 0 : 3; alt++; end
            default: v = int'($urandom % 4);
        endcase
        return v;
    endfunction

    task automatic step();
        int age;
        @(posedge clk); #1;
        cyc++;
        if (in_rst) begin
            rst_cycles++;
            if (rst_cycles >= 2) begin
                check(!chg_i && !dis_i && !astb_i && !ostb_i, "R1", "gates/strobes in reset",
                      {chg_i, dis_i, astb_i, ostb_i}, 0);
                check(code_i == 2'd0, "R1", "out_code in reset", code_i, 0);
            end
        end else begin
            if (cyc == exp_next) begin
                last_carry = cyc;
                check(dis_i && !prev_dis, carries_since_rst == 0 ? "R1" : "R7",
                      "discharge rise at predicted carry", dis_i, 1);
                carries_since_rst++;
            end
            age = cyc - last_carry;
            if (cyc == pend_set) begin
                exp_chg = 1'b1;
                pend_set = -1;
            end else if (age == 0) begin
                exp_chg = 1'b0;
            end
            check(chg_i == exp_chg, (age == 0) ? "R3" : "R2", "charge_gate", chg_i, exp_chg);
            check(dis_i == (age >= 0 && age <= 3), "R4", "discharge early half", dis_i,
                  int'(age >= 0 && age <= 3));
            check(astb_i == (age == 1), "R5", "adc_strobe early half", astb_i, int'(age == 1));
            check(ostb_i == (age == 1), "R6", "out_strobe", ostb_i, int'(age == 1));
            if (age == 1) check(int'(code_i) == v_last, "R6", "out_code", code_i, v_last);
            check({chg_e, dis_e, astb_e, ostb_e, code_e} == {chg_i, dis_i, astb_i, ostb_i, code_i},
                  "R8", "schemes differ (early half)", {chg_e, dis_e, astb_e, ostb_e, code_e},
                  {chg_i, dis_i, astb_i, ostb_i, code_i});
        end
        prev_dis = dis_i;

        @(negedge clk); #1;
        if (!in_rst) begin
            age = cyc - last_carry;
            check(dis_i == (age >= 0 && age <= 2), "R4", "discharge late half", dis_i,
                  int'(age >= 0 && age <= 2));
            check(astb_i == (age == 0), "R5", "adc_strobe late half", astb_i, int'(age == 0));
            check({dis_e, astb_e} == {dis_i, astb_i}, "R8", "schemes differ (late half)",
                  {dis_e, astb_e}, {dis_i, astb_i});
            if (age == 0) begin
                v_last = pick_code();
                adc_code = 2'(v_last);
                exp_next = cyc + period_for(v_last);
            end
        end
        if (lim_en) begin
            lim_timer--;
            if (lim_timer <= 0) begin
                lim_in = ~lim_in;
                if (lim_in) pend_set = cyc + 3;
                lim_timer = 2 + int'($urandom % 5);
            end
        end
    endtask

    task automatic do_reset(input int n);
        lim_en = 1'b0;
        lim_in = 1'b0;
        for (int i = 0; i < 5; i++) step();
        rst_n = 1'b0;
        in_rst = 1'b1;
        rst_cycles = 0;
        for (int i = 0; i < n; i++) step();
        rst_n = 1'b1;
        in_rst = 1'b0;
        exp_next = cyc + 7;
        last_carry = -1000;
        carries_since_rst = 0;
        exp_chg = 1'b0;
        pend_set = -1;
        for (int i = 0; i < 3; i++) step();
        lim_timer = 2;
        lim_en = 1'b1;
    endtask

    task automatic run(input int m, input int n);
        mode = m;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'd20251));
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step();
        in_rst = 1'b0;
        do_reset(5);
        run(0, 1500);
        run(1, 200);
        run(2, 200);
        run(3, 200);
        do_reset(3);
        run(0, 800);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog (R1..R8 run): actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule